// File: doc/BRIEF.md
# Parallel Port Extended Control and Data FIFO

This block is the host-facing control register and byte FIFO of a parallel port. A host reaches it through a simple register bus with a select strobe and a write flag. The bus carries a data port into the FIFO, a control register, and two configuration bytes. A separate protocol engine drains the FIFO in the forward direction, or fills it in the reverse direction, through a push/pop port on the peripheral side. The direction itself is an input from elsewhere in the port.

The control register holds a three-bit operating mode and three enable bits: fault-interrupt mask, DMA enable and service-interrupt control. Two read-only flags report the FIFO state. The mode decides what the FIFO does. One mode holds the FIFO in reset. A loopback test mode cuts the FIFO off from the peripheral side. A configuration mode makes the two configuration bytes visible. The service bit arms itself only once software clears it. Hardware sets it again when the condition chosen by the DMA enable and direction bits is met: terminal count, enough free space, or enough stored bytes. The interrupt output combines that pending service event with a latched falling edge of the active-low fault input.

Top module: `pport_xfifo`

## Requirements
- R1: While the mode field is 000, the FIFO is cleared within one clock. Host writes to the data offset (0x000) are then dropped and set no error.
- R2: In mode 110 the host can write and read the FIFO. `per_pop_valid` and `per_push_ready` stay 0, so a peripheral push is ignored.
- R3: The configuration bytes answer at offsets 0x400 and 0x401 only in mode 111. In any other mode those offsets read 0 and ignore writes.
- R4: The control register at offset 0x002 reads as {mode[7:5], fault mask[4], DMA enable[3], service[2], full[1], empty[0]}. It resets to 0x05. Writes to bits 1:0 have no effect.
- R5: The FIFO holds 16 bytes in arrival order. Full is set at 16 stored bytes and empty at 0.
- R6: A host write to a full FIFO is dropped. A host read of an empty FIFO returns the last byte the host read. Both cases set `err_sticky`, which stays set until reset.
- R7: `dma_req` is 1 only in modes 010 and 011 with DMA enable 1 and service bit 0. It is also 1 only when the FIFO is not full (direction 0) or not empty (direction 1).
- R8: While the service bit is 0, hardware sets it and raises `irq` when its condition holds. The condition depends on the enable bits. With DMA enabled, it is a `tc` pulse. With DMA disabled and direction 0, it is free space of at least WR_THR (8). With DMA disabled and direction 1, it is a byte count of at least RD_THR (8).
- R9: Any write to the control register clears a pending service interrupt. Writing 1 to the service bit never raises one.
- R10: A falling edge on `fault_n` latches an interrupt only in mode 011 with the fault mask at 0. A read of the control register clears the latched edge.
- R11: The peripheral port works only in modes 010 and 011. In direction 0, `per_pop_valid` shows a non-empty FIFO and `per_pop_data` shows its oldest byte. In direction 1, `per_push_ready` shows a FIFO that is not full. A host data access in the same cycle takes the FIFO and holds off the peripheral side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| dir | input | 1 | Transfer direction, 0 = forward |
| tc | input | 1 | DMA terminal count pulse |
| fault_n | input | 1 | Active-low peripheral fault |
| per_pop | input | 1 | Peripheral takes the oldest byte |
| per_pop_valid | output | 1 | A byte is available to the peripheral |
| per_pop_data | output | 8 | Oldest FIFO byte |
| per_push | input | 1 | Peripheral delivers a byte |
| per_push_data | input | 8 | Byte from the peripheral |
| per_push_ready | output | 1 | FIFO accepts a peripheral byte |
| dma_req | output | 1 | DMA service request |
| irq | output | 1 | Interrupt request |
| cfg_a | output | 8 | First configuration byte |
| cfg_b | output | 8 | Second configuration byte |
| err_sticky | output | 1 | Overflow or underflow seen since reset |

## Verification
The properties assume that `fault_n` already arrives synchronous to `clk`. They also assume that `per_pop` and `per_push` are raised only while the matching valid or ready output is 1, and that `tc` comes as a single-cycle pulse. The stimulus drives every input on the falling clock edge. It pulses `tc` and `per_push` for exactly one cycle and raises `per_pop` at random, but the reference model counts a pop only when `per_pop_valid` was shown. Direction and mode change only between bus accesses, so no threshold comparison sees a direction change in the middle of a cycle.

// File: rtl/pport_xfifo_pkg.sv
package pport_xfifo_pkg;

  typedef enum logic [2:0] {
    PM_STD   = 3'b000,
    PM_BIDIR = 3'b001,
    PM_FIFO  = 3'b010,
    PM_ECP   = 3'b011,
    PM_EPP   = 3'b100,
    PM_RSVD  = 3'b101,
    PM_TEST  = 3'b110,
    PM_CFG   = 3'b111
  } pmode_e;

  // Free space left in a FIFO of the given depth.
  function automatic int unsigned fifo_free(int unsigned used, int unsigned depth);
    return (used >= depth) ? 0 : depth - used;
  endfunction

  // Service condition: terminal count under DMA, otherwise a space or fill threshold.
  function automatic logic svc_due(logic dma_en, logic rev, logic tc_p,
                                   int unsigned used, int unsigned depth,
                                   int unsigned wthr, int unsigned rthr);
    if (dma_en) return tc_p;
    if (!rev)   return fifo_free(used, depth) >= wthr;
    return used >= rthr;
  endfunction

  // Peripheral side is attached only in the FIFO-driven modes.
  function automatic logic per_attached(logic [2:0] m);
    return (m == PM_FIFO) || (m == PM_ECP);
  endfunction

endpackage

// File: rtl/pport_xfifo_buf.sv
module pport_xfifo_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  // DEPTH is a power of two so the pointers wrap naturally.
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= push_data;
  end
endmodule

// File: rtl/pport_xfifo_fault.sv
module pport_xfifo_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_n,
  input  logic arm,
  input  logic clr,
  output logic fall,
  output logic flag
);
  logic prev_n;

  assign fall = prev_n & ~fault_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_n <= 1'b1;
      flag   <= 1'b0;
    end else begin
      prev_n <= fault_n;
      if (fall && arm) flag <= 1'b1;
      else if (clr)    flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pport_xfifo.sv
module pport_xfifo
  import pport_xfifo_pkg::*;
#(
  parameter int          AW_BUS   = 11,
  parameter int          DEPTH    = 16,
  parameter int          WR_THR   = 8,
  parameter int          RD_THR   = 8,
  parameter logic [10:0] DATA_OFS = 11'h000,
  parameter logic [10:0] CTRL_OFS = 11'h002,
  parameter logic [10:0] CFGA_OFS = 11'h400,
  parameter logic [10:0] CFGB_OFS = 11'h401
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW_BUS-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              dir,
  input  logic              tc,
  input  logic              fault_n,
  input  logic              per_pop,
  output logic              per_pop_valid,
  output logic [7:0]        per_pop_data,
  input  logic              per_push,
  input  logic [7:0]        per_push_data,
  output logic              per_push_ready,
  output logic              dma_req,
  output logic              irq,
  output logic [7:0]        cfg_a,
  output logic [7:0]        cfg_b,
  output logic              err_sticky
);
  localparam int CW = $clog2(DEPTH) + 1;

  // Control register state
  logic [2:0] mode_q;
  logic       fmask_q, dmaen_q, svc_q, svc_pend;
  logic [7:0] last_rd;

  // Decoded bus events
  logic wr_acc, rd_acc, hit_data, hit_ctrl, hit_cfga, hit_cfgb;
  logic ctrl_wr, ctrl_rd, data_wr, data_rd;
  logic fifo_on, per_on;
  logic host_push, host_pop, host_ovf, host_udf;
  logic per_pop_ok, per_push_ok;
  logic svc_evt, fault_fall, fault_flag;

  // FIFO interface
  logic [7:0]    f_head;
  logic [CW-1:0] f_count;
  logic          f_full, f_empty;

  assign wr_acc   = bus_sel & bus_wr;
  assign rd_acc   = bus_sel & ~bus_wr;
  assign hit_data = (bus_addr == DATA_OFS);
  assign hit_ctrl = (bus_addr == CTRL_OFS);
  assign hit_cfga = (bus_addr == CFGA_OFS) && (mode_q == PM_CFG);
  assign hit_cfgb = (bus_addr == CFGB_OFS) && (mode_q == PM_CFG);
  assign ctrl_wr  = wr_acc & hit_ctrl;
  assign ctrl_rd  = rd_acc & hit_ctrl;
  assign data_wr  = wr_acc & hit_data;
  assign data_rd  = rd_acc & hit_data;

  assign fifo_on   = (mode_q != PM_STD);
  assign per_on    = per_attached(mode_q);
  assign host_push = data_wr & fifo_on & ~f_full;
  assign host_pop  = data_rd & fifo_on & ~f_empty;
  assign host_ovf  = data_wr & fifo_on & f_full;
  assign host_udf  = data_rd & fifo_on & f_empty;

  // Host access owns the FIFO in its cycle
  assign per_pop_valid  = per_on & ~dir & ~f_empty & ~data_rd;
  assign per_push_ready = per_on & dir & ~f_full & ~data_wr;
  assign per_pop_ok     = per_pop & per_pop_valid;
  assign per_push_ok    = per_push & per_push_ready;
  assign per_pop_data   = f_head;

  assign svc_evt = ~svc_q & svc_due(dmaen_q, dir, tc, 32'(f_count), DEPTH, WR_THR, RD_THR);
  assign dma_req = dmaen_q & ~svc_q & per_on & (dir ? ~f_empty : ~f_full);
  assign irq     = svc_pend | fault_flag;

  pport_xfifo_buf #(.DEPTH(DEPTH), .DW(8)) buf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (mode_q == PM_STD),
    .push      (host_push | per_push_ok),
    .push_data (host_push ? bus_wdata : per_push_data),
    .pop       (host_pop | per_pop_ok),
    .head      (f_head),
    .count     (f_count),
    .full      (f_full),
    .empty     (f_empty)
  );

  pport_xfifo_fault fault_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .fault_n (fault_n),
    .arm     ((mode_q == PM_ECP) && !fmask_q),
    .clr     (ctrl_rd),
    .fall    (fault_fall),
    .flag    (fault_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= PM_STD;
      fmask_q  <= 1'b0;
      dmaen_q  <= 1'b0;
      svc_q    <= 1'b1;
      svc_pend <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q   <= bus_wdata[7:5];
      fmask_q  <= bus_wdata[4];
      dmaen_q  <= bus_wdata[3];
      svc_q    <= bus_wdata[2];
      svc_pend <= 1'b0;
    end else if (svc_evt) begin
      svc_q    <= 1'b1;
      svc_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_a      <= '0;
      cfg_b      <= '0;
      last_rd    <= '0;
      err_sticky <= 1'b0;
    end else begin
      if (wr_acc && hit_cfga) cfg_a <= bus_wdata;
      if (wr_acc && hit_cfgb) cfg_b <= bus_wdata;
      if (host_pop)           last_rd <= f_head;
      if (host_ovf || host_udf) err_sticky <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_data)      bus_rdata = f_empty ? last_rd : f_head;
    else if (hit_ctrl) bus_rdata = {mode_q, fmask_q, dmaen_q, svc_q, f_full, f_empty};
    else if (hit_cfga) bus_rdata = cfg_a;
    else if (hit_cfgb) bus_rdata = cfg_b;
  end
endmodule

// File: rtl/pport_xfifo_chk.sv
module pport_xfifo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_wr,
  input logic [7:0]  bus_wdata,
  input logic        data_wr,
  input logic [2:0]  mode_q,
  input logic        fmask_q,
  input logic        dmaen_q,
  input logic        svc_q,
  input logic        svc_pend,
  input logic        f_full,
  input logic        f_empty,
  input logic        per_pop_valid,
  input logic        per_push_ready,
  input logic        dma_req,
  input logic        irq,
  input logic        fault_fall,
  input logic        err_sticky
);
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_full && f_empty));

  a_r1_std_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b000) |=> f_empty);

  a_r2_test_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b110) |-> (!per_pop_valid && !per_push_ready));

  a_r7_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dmaen_q && !svc_q));

  a_r8_pend_implies_svc: assert property (@(posedge clk) disable iff (!rst_n)
    svc_pend |-> svc_q);

  a_r9_write_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[2]) |=> !svc_pend);

  a_r10_fault_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_fall && mode_q == 3'b011 && !fmask_q && !ctrl_wr) |=> irq);

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && f_full && mode_q != 3'b000) |=> err_sticky);
endmodule

bind pport_xfifo pport_xfifo_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctrl_wr        (ctrl_wr),
  .bus_wdata      (bus_wdata),
  .data_wr        (data_wr),
  .mode_q         (mode_q),
  .fmask_q        (fmask_q),
  .dmaen_q        (dmaen_q),
  .svc_q          (svc_q),
  .svc_pend       (svc_pend),
  .f_full         (f_full),
  .f_empty        (f_empty),
  .per_pop_valid  (per_pop_valid),
  .per_push_ready (per_push_ready),
  .dma_req        (dma_req),
  .irq            (irq),
  .fault_fall     (fault_fall),
  .err_sticky     (err_sticky)
);

// File: tb/pport_xfifo_tb.sv
module pport_xfifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        dir = 1'b0, tc = 1'b0, fault_n = 1'b1;
  logic        per_pop = 1'b0, per_push = 1'b0;
  logic [7:0]  per_push_data = '0;
  logic        per_pop_valid, per_push_ready, dma_req, irq, err_sticky;
  logic [7:0]  per_pop_data, cfg_a, cfg_b;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] last_exp;
  logic [7:0] q [$];

  always #2 clk = ~clk;

  pport_xfifo dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dir(dir), .tc(tc), .fault_n(fault_n), .per_pop(per_pop),
    .per_pop_valid(per_pop_valid), .per_pop_data(per_pop_data),
    .per_push(per_push), .per_push_data(per_push_data),
    .per_push_ready(per_push_ready), .dma_req(dma_req), .irq(irq),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .err_sticky(err_sticky)
  );

  // Expected control byte, rebuilt from field meanings.
  function automatic logic [7:0] ctrl_exp(logic [2:0] m, logic fm, logic de,
                                          logic sv, int cnt);
    logic [7:0] v;
    v = 8'(m) << 5;
    v = v | (fm ? 8'h10 : 8'h00) | (de ? 8'h08 : 8'h00) | (sv ? 8'h04 : 8'h00);
    if (cnt == 16) v = v + 8'd2;
    if (cnt == 0)  v = v + 8'd1;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] rd;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    br(11'h002, rd);
    check("R4 reset ctrl", rd, 8'h05);
    check("R7 reset dma", dma_req, 0);
    check("R8 reset irq", irq, 0);
    check("R6 reset err", err_sticky, 0);

    // R1: data write in mode 000 is dropped without error
    bw(11'h000, 8'h11);
    bw(11'h002, 8'hC7);  // test mode, svc=1, low bits written as 1
    br(11'h002, rd);
    check("R1 std write dropped / R4 ro bits", rd, ctrl_exp(3'b110, 0, 0, 1, 0));
    check("R1 no error", err_sticky, 0);

    // R2/R5/R6: fill in test mode
    for (int i = 0; i < 16; i++) bw(11'h000, 8'(i * 7 + 3));
    br(11'h002, rd);
    check("R5 full flag", rd, ctrl_exp(3'b110, 0, 0, 1, 16));
    check("R2 no pop valid", per_pop_valid, 0);
    bw(11'h000, 8'hEE);
    check("R6 overflow sticky", err_sticky, 1);
    for (int i = 0; i < 16; i++) begin
      br(11'h000, rd);
      check("R5 order", rd, 8'(i * 7 + 3));
    end
    br(11'h000, rd);
    check("R6 underflow returns last", rd, 8'(15 * 7 + 3));
    dir = 1'b1;
    @(negedge clk);
    check("R2 no push ready", per_push_ready, 0);
    per_push = 1'b1; per_push_data = 8'h5A;
    @(negedge clk);
    per_push = 1'b0; dir = 1'b0;
    br(11'h002, rd);
    check("R2 push ignored", rd, ctrl_exp(3'b110, 0, 0, 1, 0));

    // R1: entering mode 000 clears stored bytes
    for (int i = 0; i < 3; i++) bw(11'h000, 8'h30);
    bw(11'h002, 8'h04);
    bw(11'h002, 8'hC4);
    br(11'h002, rd);
    check("R1 clear on std", rd, ctrl_exp(3'b110, 0, 0, 1, 0));

    // R3: configuration bytes
    bw(11'h400, 8'h99);
    br(11'h400, rd);
    check("R3 hidden read", rd, 0);
    bw(11'h002, 8'hE4);
    br(11'h400, rd);
    check("R3 hidden write ignored", rd, 0);
    bw(11'h400, 8'hA5);
    bw(11'h401, 8'h3C);
    br(11'h400, rd);
    check("R3 cfg_a read", rd, 8'hA5);
    br(11'h401, rd);
    check("R3 cfg_b read", rd, 8'h3C);
    check("R3 cfg outputs", {cfg_a, cfg_b}, 16'hA53C);

    // R8/R9/R11: thresholds
    bw(11'h002, 8'h44);
    for (int i = 0; i < 9; i++) bw(11'h000, 8'(8'h20 + i));
    bw(11'h002, 8'h40);
    idle(3);
    check("R8 free 7 below threshold", irq, 0);
    check("R7 dma off when disabled", dma_req, 0);
    check("R11 pop valid", per_pop_valid, 1);
    check("R11 pop data", per_pop_data, 8'h20);
    per_pop = 1'b1;
    @(negedge clk);
    per_pop = 1'b0;
    @(negedge clk);
    check("R8 free 8 fires", irq, 1);
    br(11'h002, rd);
    check("R8 svc self set", rd, ctrl_exp(3'b010, 0, 0, 1, 8));
    bw(11'h002, 8'h44);
    check("R9 write clears pending", irq, 0);
    dir = 1'b1;
    bw(11'h002, 8'h40);
    @(negedge clk);
    check("R8 reverse count 8 fires", irq, 1);
    bw(11'h002, 8'h44);
    dir = 1'b0;
    idle(2);
    check("R9 svc=1 raises nothing", irq, 0);

    // R7/R8: DMA and terminal count
    bw(11'h002, 8'h04);
    bw(11'h002, 8'h48);
    check("R7 dma request", dma_req, 1);
    check("R8 no event without tc", irq, 0);
    @(negedge clk);
    tc = 1'b1;
    @(negedge clk);
    tc = 1'b0;
    check("R7 dma drops after tc", dma_req, 0);
    check("R8 tc fires", irq, 1);
    br(11'h002, rd);
    check("R8 svc after tc", rd, ctrl_exp(3'b010, 0, 1, 1, 0));

    // R10: fault edge
    bw(11'h002, 8'h64);
    check("R10 quiet before edge", irq, 0);
    fault_n = 1'b0;
    idle(2);
    check("R10 edge latched", irq, 1);
    br(11'h002, rd);
    check("R10 read clears", irq, 0);
    fault_n = 1'b1;
    bw(11'h002, 8'h74);
    fault_n = 1'b0;
    idle(2);
    check("R10 masked", irq, 0);
    fault_n = 1'b1;
    bw(11'h002, 8'h44);
    fault_n = 1'b0;
    idle(2);
    check("R10 other mode", irq, 0);
    fault_n = 1'b1;

    // R11: reverse push
    dir = 1'b1;
    @(negedge clk);
    check("R11 push ready", per_push_ready, 1);
    per_push = 1'b1; per_push_data = 8'h77;
    @(negedge clk);
    per_push = 1'b0; dir = 1'b0;
    br(11'h000, rd);
    check("R11 pushed byte", rd, 8'h77);
    last_exp = 8'h77;

    // Random forward traffic against a queue model
    void'($urandom(32'd1234));
    for (int it = 0; it < 400; it++) begin
      int unsigned op, pp, pre;
      logic [7:0] wd;
      logic exp_pv;
      @(negedge clk);
      op = $urandom % 3; pp = $urandom % 2; wd = 8'($urandom);
      bus_sel = (op != 0); bus_wr = (op == 1); bus_addr = 11'h000; bus_wdata = wd;
      per_pop = pp[0];
      #1;
      pre = q.size();
      exp_pv = (pre != 0) && (op != 2);
      check("R11 random pop valid", per_pop_valid, exp_pv);
      if (exp_pv) check("R5 random head", per_pop_data, q[0]);
      if (op == 2) check("R6 random read", bus_rdata, (pre != 0) ? q[0] : last_exp);
      if (op == 2 && pre != 0) last_exp = q.pop_front();
      else if (pp != 0 && exp_pv) void'(q.pop_front());
      if (op == 1 && pre < 16) q.push_back(wd);
    end
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; per_pop = 1'b0;
    br(11'h002, rd);
    check("R5 random final flags", rd, ctrl_exp(3'b010, 0, 0, 1, q.size()));
    summary();
  end
endmodule